// File: doc/BRIEF.md
# Misaligned Word Load Unit

This unit sits between a processor load port and a memory whose data bus is one word (four bytes) wide and can only return naturally aligned words. A load request carries a byte address, a size code and a signed flag. The unit turns the request into one aligned bus read, or into two if the requested bytes run past the end of one word. It then shifts the returned bytes into place, merges them, orders them by the selected byte order and widens the value to a full register.

Endianness comes from a static input. In little-endian order the lowest-addressed byte is the least significant. In big-endian order it is the most significant. Byte loads never straddle a word. Halfword and word loads are split only when they cross a word boundary. A flag beside the result tells the requester that the access needed two bus reads.

Top module: `mwl_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req_ready` is 1, and `ld_valid` and `mem_rd_valid` are 0.
- R2: A request is taken only in a cycle where `req_ready` is 1. Changes to `req_addr`, `req_size` or `req_signed` while the unit is busy have no effect on the reads issued or on the result.
- R3: If the byte offset within the word plus the access length is at most 4, exactly one read is issued. Its address is the request address with bits 1:0 cleared, and `ld_split` is 0 with the result.
- R4: If the access runs past the end of its word, two reads are issued: the lower word first, then the word at that address plus 4 (modulo 2^ADDR_W). `ld_split` is 1 with the result.
- R5: In every response word, bits 8i+7:8i hold the byte at word address + i, whatever the byte order.
- R6: With `big_endian` = 0, the byte at the request address lands in result bits 7:0, and each following address goes one byte higher.
- R7: With `big_endian` = 1, the byte at the request address lands in the most significant byte of the n-byte value (bits 8n-1:8n-8), and each following address goes one byte lower.
- R8: Size code 0 is a byte, 1 a halfword, 2 a word. With `req_signed` = 1, byte and halfword results are sign-extended from their top bit. With `req_signed` = 0 they are zero-extended. Word results are not affected by `req_signed`.
- R9: `ld_valid` is high for exactly one cycle: the cycle after the one in which the last read response is accepted. `req_ready` is 1 again in the next cycle.
- R10: `mem_rd_valid` is a one-cycle pulse per read. No read is issued while a response is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static byte-order select (1 = big-endian) |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle; request taken this cycle if valid |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend (1) or zero-extend (0) |
| mem_rd_valid | output | 1 | Aligned word read strobe |
| mem_rd_addr | output | ADDR_W | Word-aligned byte address of the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Returned word, lane i = byte address + i |
| ld_valid | output | 1 | Result present (one cycle) |
| ld_data | output | 32 | Assembled, extended load value |
| ld_split | output | 1 | Access needed two bus reads |

## Verification
The bench builds the unit with a 12-bit address and the default four-byte bus. A full sweep of all byte offsets, sizes, sign modes and both byte orders is therefore cheap. Split reads at the top of the space wrap to address zero, so wrap-around is covered. The bench adds response latencies of zero to two extra cycles and changes request inputs while the unit is busy. Each result is checked against a value computed arithmetically from a byte-per-address memory pattern.

// File: rtl/mwl_pkg.sv
`timescale 1ns/1ps
package mwl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ0  = 3'd1,
      ST_WAIT0 = 3'd2,
      ST_REQ1  = 3'd3,
      ST_WAIT1 = 3'd4,
      ST_DONE  = 3'd5
   } mwl_state_e;

endpackage

// File: rtl/mwl_seq.sv
`timescale 1ns/1ps
module mwl_seq
   import mwl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BUS_BYTES = 4,
   parameter int unsigned SIZE_W    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic [SIZE_W-1:0]            req_size,
   input  logic                         req_signed,
   output logic                         req_ready,
   output logic                         mem_rd_valid,
   output logic [ADDR_W-1:0]            mem_rd_addr,
   input  logic                         mem_rsp_valid,
   output logic                         cap0,
   output logic                         cap1,
   output logic                         done,
   output logic                         split_q,
   output logic [$clog2(BUS_BYTES)-1:0] off_q,
   output logic [SIZE_W-1:0]            size_q,
   output logic                         sgn_q
);

   localparam int unsigned       OFF_W  = $clog2(BUS_BYTES);
   localparam logic [SIZE_W-1:0] MAX_LG = SIZE_W'(OFF_W);

   mwl_state_e          state_q, state_d;
   logic [ADDR_W-1:0]   base_q;
   logic [SIZE_W-1:0]   size_eff;
   logic [OFF_W:0]      span_end;
   logic                crosses;
   logic                accept;

   // Oversized codes collapse onto a full word.
   assign size_eff = (req_size > MAX_LG) ? MAX_LG : req_size;
   assign span_end = {1'b0, req_addr[OFF_W-1:0]} + ((OFF_W+1)'(1) << size_eff);
   assign crosses  = span_end > (OFF_W+1)'(BUS_BYTES);
   assign accept   = (state_q == ST_IDLE) && req_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_REQ0;
         ST_REQ0:  state_d = ST_WAIT0;
         ST_WAIT0: if (mem_rsp_valid) state_d = split_q ? ST_REQ1 : ST_DONE;
         ST_REQ1:  state_d = ST_WAIT1;
         ST_WAIT1: if (mem_rsp_valid) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         off_q   <= '0;
         size_q  <= '0;
         sgn_q   <= 1'b0;
         split_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            base_q  <= {req_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
            off_q   <= req_addr[OFF_W-1:0];
            size_q  <= size_eff;
            sgn_q   <= req_signed;
            split_q <= crosses;
         end
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign mem_rd_valid = (state_q == ST_REQ0) || (state_q == ST_REQ1);
   assign mem_rd_addr  = base_q + ((state_q == ST_REQ1) ? ADDR_W'(BUS_BYTES) : '0);
   assign cap0         = (state_q == ST_WAIT0) && mem_rsp_valid;
   assign cap1         = (state_q == ST_WAIT1) && mem_rsp_valid;
   assign done         = (state_q == ST_DONE);

   // R10: a read strobe never lasts two cycles
   a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |=> !mem_rd_valid);

   // R10: responses arrive only while one is awaited
   a_r10_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> (state_q == ST_WAIT0 || state_q == ST_WAIT1));

   // R4: the second read only follows an accepted first response
   a_r4_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REQ1) |-> ($past(state_q) == ST_WAIT0 && $past(mem_rsp_valid)));

   // R3: an access inside one word finishes after its single response
   a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      (cap0 && !split_q) |=> (done && !mem_rd_valid));

   // R3/R4: every read address is word aligned
   a_r3_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr[OFF_W-1:0] == '0));

endmodule

// File: rtl/mwl_lane_merge.sv
`timescale 1ns/1ps
module mwl_lane_merge #(
   parameter int unsigned BUS_BYTES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cap0,
   input  logic                         cap1,
   input  logic [8*BUS_BYTES-1:0]       rsp_data,
   input  logic [$clog2(BUS_BYTES)-1:0] off,
   output logic [8*BUS_BYTES-1:0]       window
);

   localparam int unsigned DATA_W = 8 * BUS_BYTES;

   logic [DATA_W-1:0]   lo_q, hi_q;
   logic [2*DATA_W-1:0] pair;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (cap0) lo_q <= rsp_data;
         if (cap1) hi_q <= rsp_data;
      end
   end

   assign pair = {hi_q, lo_q};

   // Window byte k is the byte at request address + k.
   for (genvar k = 0; k < BUS_BYTES; k++) begin : g_win
      assign window[8*k +: 8] = pair[(int'(off) + k) * 8 +: 8];
   end

   // R5: the two captures never happen in the same cycle
   a_r5_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap0 && cap1));

endmodule

// File: rtl/mwl_order_extend.sv
`timescale 1ns/1ps
module mwl_order_extend #(
   parameter int unsigned BUS_BYTES = 4,
   parameter int unsigned SIZE_W    = 2
) (
   input  logic [8*BUS_BYTES-1:0] window,
   input  logic [SIZE_W-1:0]      size_lg,
   input  logic                   sgn,
   input  logic                   big_endian,
   output logic [8*BUS_BYTES-1:0] value
);

   int unsigned nb;
   logic [7:0]  top_byte;
   logic [7:0]  fill;

   assign nb = 32'd1 << size_lg;

   // Most significant loaded byte: last address in LE, first in BE.
   always_comb begin
      if (big_endian) top_byte = window[7:0];
      else            top_byte = window[(nb - 1) * 8 +: 8];
      fill = (sgn && top_byte[7]) ? 8'hFF : 8'h00;
   end

   for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
      always_comb begin
         if (j < nb) begin
            if (big_endian) value[8*j +: 8] = window[(nb - 1 - j) * 8 +: 8];
            else            value[8*j +: 8] = window[8*j +: 8];
         end else begin
            value[8*j +: 8] = fill;
         end
      end
   end

endmodule

// File: rtl/mwl_unit.sv
`timescale 1ns/1ps
module mwl_unit #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BUS_BYTES = 4,
   localparam int unsigned SIZE_W   = $clog2($clog2(BUS_BYTES) + 1),
   localparam int unsigned DATA_W   = 8 * BUS_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_signed,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data,
   output logic              ld_split
);

   localparam int unsigned OFF_W = $clog2(BUS_BYTES);

   if (BUS_BYTES < 2 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("mwl_unit: BUS_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("mwl_unit: ADDR_W must exceed the byte-offset width");
   end

   logic              cap0, cap1, done, split_q, sgn_q;
   logic [OFF_W-1:0]  off_q;
   logic [SIZE_W-1:0] size_q;
   logic [DATA_W-1:0] window, value;

   mwl_seq #(
      .ADDR_W   (ADDR_W),
      .BUS_BYTES(BUS_BYTES),
      .SIZE_W   (SIZE_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .req_size     (req_size),
      .req_signed   (req_signed),
      .req_ready    (req_ready),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .cap0         (cap0),
      .cap1         (cap1),
      .done         (done),
      .split_q      (split_q),
      .off_q        (off_q),
      .size_q       (size_q),
      .sgn_q        (sgn_q)
   );

   mwl_lane_merge #(
      .BUS_BYTES(BUS_BYTES)
   ) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap0    (cap0),
      .cap1    (cap1),
      .rsp_data(mem_rsp_data),
      .off     (off_q),
      .window  (window)
   );

   mwl_order_extend #(
      .BUS_BYTES(BUS_BYTES),
      .SIZE_W   (SIZE_W)
   ) u_order (
      .window    (window),
      .size_lg   (size_q),
      .sgn       (sgn_q),
      .big_endian(big_endian),
      .value     (value)
   );

   assign ld_valid = done;
   assign ld_data  = done ? value : '0;
   assign ld_split = done && split_q;

   // R9: result lasts one cycle, then the unit is ready again
   a_r9_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> (!ld_valid && req_ready));

   // R8: unsigned byte loads carry zeros above bit 7
   a_r8_zero_ext_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !sgn_q && size_q == '0) |-> (ld_data[DATA_W-1:8] == '0));

   // R2: no read is launched while a result is being presented
   a_r2_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> (!mem_rd_valid && !req_ready));

endmodule

// File: tb/mwl_unit_tb_top.sv
`timescale 1ns/1ps
module mwl_unit_tb_top;

   localparam int unsigned AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          big_endian = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = '0;
   logic          req_signed = 1'b0;
   logic          mem_rd_valid;
   logic [AW-1:0] mem_rd_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [31:0]   mem_rsp_data = '0;
   logic          ld_valid;
   logic [31:0]   ld_data;
   logic          ld_split;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   int unsigned cyc = 0;
   int unsigned lat = 0;
   int unsigned n_reads = 0;
   int unsigned last_rsp_cyc = 0;
   logic [AW-1:0] rd_log [0:3];

   mwl_unit #(.ADDR_W(AW), .BUS_BYTES(4)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .big_endian   (big_endian),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .req_size     (req_size),
      .req_signed   (req_signed),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .ld_valid     (ld_valid),
      .ld_data      (ld_data),
      .ld_split     (ld_split)
   );

   initial forever #4 clk = ~clk;
   initial forever begin @(posedge clk); cyc++; end

   function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
      int unsigned v;
      v = (int'(a) * 29 + 91) ^ (int'(a) >> 5);
      return v[7:0];
   endfunction

   // R5: lane i carries byte address + i
   function automatic logic [31:0] mword(input logic [AW-1:0] a);
      return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
   endfunction

   function automatic logic [31:0] expect_val(input logic [AW-1:0] a, input int sz,
                                              input bit sgn, input bit be);
      int n;
      logic [31:0] v;
      n = 1 << sz;
      v = '0;
      for (int k = 0; k < n; k++) begin
         if (be) v |= 32'(mbyte(a + AW'(k))) << (8 * (n - 1 - k));
         else    v |= 32'(mbyte(a + AW'(k))) << (8 * k);
      end
      if (n < 4 && sgn && v[8*n-1]) v |= ~((32'd1 << (8 * n)) - 32'd1);
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Memory model: one response per read, 1+lat cycles later
   initial forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_rd_valid) begin
         logic [AW-1:0] ra;
         ra = mem_rd_addr;
         if (n_reads < 4) rd_log[n_reads] = ra;
         n_reads++;
         repeat (lat) @(negedge clk);
         @(negedge clk);
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = mword(ra);
         last_rsp_cyc  = cyc;
      end
   end

   task automatic run_vec(input logic [AW-1:0] a, input int sz, input bit sgn,
                          input bit be, input bit noise);
      logic [31:0]   exp;
      bit            xs;
      logic [AW-1:0] w0;
      int            guard;
      exp = expect_val(a, sz, sgn, be);
      xs  = (int'(a[1:0]) + (1 << sz)) > 4;
      w0  = {a[AW-1:2], 2'b00};
      @(negedge clk);
      n_reads    = 0;
      big_endian = be;
      req_addr   = a;
      req_size   = 2'(sz);
      req_signed = sgn;
      req_valid  = 1'b1;
      @(negedge clk);
      if (noise) begin
         // R2: disturb request inputs while busy
         req_addr   = a ^ 12'h5A3;
         req_size   = 2'(2 - sz);
         req_signed = !sgn;
      end else begin
         req_valid = 1'b0;
      end
      guard = 0;
      while (!ld_valid && guard < 40) begin
         @(negedge clk);
         guard++;
      end
      req_valid = 1'b0;
      if (!ld_valid) begin
         chk(1'b0, "R9 no result", 32'(guard), 32'd0);
         return;
      end
      if (be) chk(ld_data == exp, sgn ? "R7/R8 be data" : "R7 be data", ld_data, exp);
      else    chk(ld_data == exp, sgn ? "R6/R8 le data" : "R6 le data", ld_data, exp);
      chk(ld_split == xs, xs ? "R4 split flag" : "R3 split flag", 32'(ld_split), 32'(xs));
      chk(n_reads == (xs ? 2 : 1), xs ? "R4 read count" : "R3 read count",
          32'(n_reads), xs ? 32'd2 : 32'd1);
      chk(rd_log[0] == w0, "R3 first read addr", 32'(rd_log[0]), 32'(w0));
      if (xs) chk(rd_log[1] == w0 + AW'(4), "R4 second read addr",
                  32'(rd_log[1]), 32'(w0 + AW'(4)));
      chk(cyc == last_rsp_cyc + 1, "R9 result timing", 32'(cyc), 32'(last_rsp_cyc + 1));
      @(negedge clk);
      chk(!ld_valid && req_ready, "R9 one-cycle result", 32'({ld_valid, req_ready}), 32'b01);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [AW-1:0] bases [0:5];
      int            idx;
      bases[0] = 12'h000; bases[1] = 12'h104; bases[2] = 12'h7F8;
      bases[3] = 12'hFFC; bases[4] = 12'h3A0; bases[5] = 12'hABC;
      repeat (3) @(negedge clk);
      chk(req_ready && !ld_valid && !mem_rd_valid, "R1 reset state",
          32'({req_ready, ld_valid, mem_rd_valid}), 32'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !ld_valid && !mem_rd_valid, "R1 after reset",
          32'({req_ready, ld_valid, mem_rd_valid}), 32'b100);
      idx = 0;
      for (int b = 0; b < 6; b++)
         for (int o = 0; o < 4; o++)
            for (int sz = 0; sz < 3; sz++)
               for (int s = 0; s < 2; s++)
                  for (int e = 0; e < 2; e++) begin
                     lat = idx % 3;
                     run_vec(bases[b] + AW'(o), sz, s[0], e[0], (idx % 5) == 0);
                     idx++;
                  end
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule